// File: doc/BRIEF.md
# DLL Channel Control Serial Register Slave

This block is the slow-control port of a four-channel delay-locked-loop clock generator. An external serial master uses it to program the per-channel clock phase, output-enable and drive-strength settings. Through the same port the master reads back lock and error flags, clears the charge pumps, and loops the serial line through for board test. The analog loops are not part of this block. Only their digital configuration words, status flags and pump-clear strobe appear at its ports.

Each frame opens with an 8-bit command byte. For a configuration access 16 data bits follow; for a status access 8 data bits follow. The serial clock idles low (SPI mode 1). The master changes data on the rising edge and the slave samples on the falling edge. The slave oversamples SCLK, chip select and SDI with the system clock through synchronizer chains. Configuration words are held as three copies, and a bitwise majority vote feeds both the outputs and read-back, so one upset copy cannot reach a port. The serial output never drives high: the block only pulls the line low, like an open-drain pad.

Top module: `dllcfg_spi_slave`

## Requirements
- R1: While `rst_n` is low and after it rises, every configuration word reads 0x9E00, `spi_sdo_pull` is 0, `pump_clr` is 0 and `tmr_mismatch` is 0.
- R2: With `spi_cs_n` low, the first 8 SDI bits are taken MSB first on falling SCLK edges as the command. Bit 7 = read (1) or write (0), bit 6 = pump clear, bit 5 = status bank (1) or configuration bank (0), and bits 4..0 = register index.
- R3: A write command to the configuration bank with index below 8 stores the next 16 SDI bits, MSB first, and the word then appears on `cfg_word[idx*16 +: 16]`. Bit 15 is output clock enable, bits 13..9 and 8..4 are the two phase selects, bit 3 is monitor enable, bit 2 is pad output enable, and bits 1..0 select drive current.
- R4: A configuration read returns the 16-bit word MSB first, one bit per rising SCLK edge, starting with the rising edge that follows the command byte. `spi_sdo_pull` is 1 exactly when the bit is 0.
- R5: Each configuration word is held as three copies. A write updates all three, the outputs carry the majority vote, and `tmr_mismatch` stays 0 in fault-free operation.
- R6: A command with bit 6 set, other than 0xFF, gives exactly one single-cycle `pump_clr` pulse per frame and touches no register.
- R7: A write frame that ends, with `spi_cs_n` high, before its 16th data bit leaves every configuration word unchanged.
- R8: A status read of index ch < 4 returns {`chan_stat[ch*3+2]` too-slow error, `chan_stat[ch*3+1]` locked, `chan_stat[ch*3]` near-cutoff warning, 00000}, captured at the end of the command byte. Indices 4 and above return 0x00.
- R9: Command 0xFF loops SDI to the serial output for the rest of the frame, and it writes no register and gives no pump pulse.
- R10: Pad output enable (bit 2) is stored only in the configuration word at index 2. At every other index it is stored and read as 0.
- R11: Writes to the status bank or to configuration indices 8 to 31 are ignored. Configuration reads at those indices return 0x0000.
- R12: `spi_sdo_pull` is 0 while `spi_cs_n` is high and during the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset; also presets configuration words |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Frame enable, active low |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo_pull | output | 1 | 1 pulls the serial output low; 0 releases it |
| chan_stat | input | 12 | Per channel {too slow, locked, near cutoff} |
| cfg_word | output | 128 | Eight voted 16-bit configuration words |
| pump_clr | output | 1 | One-cycle charge-pump clear strobe |
| tmr_mismatch | output | 1 | Debug: some stored copy disagrees with its siblings |

## Verification
A decode error in the command state shows at the next frame boundary: the wrong word changes on `cfg_word`, a stray `pump_clr` pulse appears, or the line is pulled low during the command byte. A wrong bit count or shift alignment shows within one frame as a read-back that is rotated or cut short, or as a commit after an aborted frame. A copy that lags its siblings raises `tmr_mismatch` on the cycle after the write that should have updated it. A lost pad-bit mask shows in the next read of any index other than 2.

// File: rtl/dllcfg_pkg.sv
package dllcfg_pkg;

   typedef struct packed {
      logic       rd;
      logic       pump;
      logic       stat;
      logic [4:0] idx;
   } cmd_t;

   localparam logic [7:0]  LOOP_CMD   = 8'hFF;
   localparam logic [15:0] CFG_PRESET = 16'h9E00;

   function automatic logic [15:0] vote3(input logic [15:0] a,
                                         input logic [15:0] b,
                                         input logic [15:0] c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic sdi,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic active,
   output logic sdi_s
);
   localparam int LAST = STAGES - 1;

   logic [2:0] chain [STAGES];
   logic       sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= 3'b011;
         sclk_d <= 1'b0;
      end else begin
         chain[0] <= {sclk, cs_n, sdi};
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
         sclk_d <= chain[LAST][2];
      end
   end

   assign sclk_rise = chain[LAST][2] & ~sclk_d;
   assign sclk_fall = ~chain[LAST][2] & sclk_d;
   assign active    = ~chain[LAST][1];
   assign sdi_s     = chain[LAST][0];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
   import dllcfg_pkg::*;
#(
   parameter int CW = 8,
   parameter int DW = 16,
   parameter int SW = 8,
   localparam int IW = CW - 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk_rise,
   input  logic          sclk_fall,
   input  logic          active,
   input  logic          sdi_s,
   output logic [IW-1:0] rd_idx,
   input  logic [DW-1:0] rd_cfg,
   input  logic [SW-1:0] rd_stat,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic [DW-1:0] wr_data,
   output logic          pump_clr,
   output logic          drv_low
);
   localparam int FRAME_W = CW + DW;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_CMD_END = CNT_W'(CW);
   localparam logic [CNT_W-1:0] CNT_CMD_LST = CNT_W'(CW - 1);
   localparam logic [CNT_W-1:0] CNT_FRM_END = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_FRM_LST = CNT_W'(FRAME_W - 1);

   logic [CNT_W-1:0] bit_cnt;
   logic [CW-2:0]    cmd_sh;
   logic [DW-2:0]    rx_sh;
   logic [DW-1:0]    tx_sh;
   logic             tx_armed, loop_on, is_wr, sdo_bit;
   logic [CW-1:0]    full;
   cmd_t             cmd;

   assign full   = {cmd_sh, sdi_s};
   assign cmd    = cmd_t'(full);
   assign rd_idx = cmd.idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         cmd_sh   <= '0;
         rx_sh    <= '0;
         tx_sh    <= '1;
         tx_armed <= 1'b0;
         loop_on  <= 1'b0;
         is_wr    <= 1'b0;
         sdo_bit  <= 1'b1;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
         pump_clr <= 1'b0;
      end else begin
         wr_en    <= 1'b0;
         pump_clr <= 1'b0;
         if (!active) begin
            bit_cnt  <= '0;
            tx_armed <= 1'b0;
            loop_on  <= 1'b0;
            is_wr    <= 1'b0;
            sdo_bit  <= 1'b1;
         end else begin
            if (sclk_fall) begin
               if (bit_cnt != CNT_FRM_END) bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt < CNT_CMD_END) cmd_sh <= full[CW-2:0];
               else                       rx_sh  <= {rx_sh[DW-3:0], sdi_s};
               if (bit_cnt == CNT_CMD_LST) begin
                  if (full == LOOP_CMD) begin
                     loop_on <= 1'b1;
                  end else if (cmd.pump) begin
                     pump_clr <= 1'b1;
                  end else if (cmd.rd) begin
                     tx_armed <= 1'b1;
                     tx_sh    <= cmd.stat ? {rd_stat, {(DW-SW){1'b1}}} : rd_cfg;
                  end else if (!cmd.stat) begin
                     is_wr  <= 1'b1;
                     wr_idx <= cmd.idx;
                  end
               end
               if (bit_cnt == CNT_FRM_LST && is_wr) begin
                  wr_en   <= 1'b1;
                  wr_data <= {rx_sh, sdi_s};
               end
            end
            if (sclk_rise && tx_armed) begin
               sdo_bit <= tx_sh[DW-1];
               tx_sh   <= {tx_sh[DW-2:0], 1'b1};
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_low <= 1'b0;
      else        drv_low <= active & (loop_on ? ~sdi_s : ~sdo_bit);
   end

   p_commit_full_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> bit_cnt == CNT_FRM_END)
      else $error("write committed before the full data word");

   p_loop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      loop_on |-> (!wr_en && !pump_clr && !tx_armed))
      else $error("loop-through frame touched registers or pump");

   p_pump_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pump_clr |=> !pump_clr)
      else $error("pump clear longer than one cycle");

   p_cmd_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt < CNT_CMD_END) && !loop_on |=> !drv_low)
      else $error("serial output pulled during command byte");

endmodule

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank
   import dllcfg_pkg::*;
#(
   parameter int NREG    = 8,
   parameter int DW      = 16,
   parameter int IW      = 5,
   parameter int PAD_IDX = 2,
   parameter int PAD_BIT = 2,
   parameter logic [DW-1:0] PRESET = CFG_PRESET
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IW-1:0]      wr_idx,
   input  logic [DW-1:0]      wr_data,
   input  logic [IW-1:0]      rd_idx,
   output logic [DW-1:0]      rd_data,
   output logic [NREG*DW-1:0] cfg_flat,
   output logic               mismatch
);
   logic [DW-1:0] voted [NREG];
   logic [NREG-1:0] mism;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam logic [IW-1:0] MY_IDX = IW'(r);
      localparam logic [DW-1:0] KEEP   = (r == PAD_IDX) ? '1 : ~(DW'(1) << PAD_BIT);
      logic [DW-1:0] cp [3];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < 3; k++) cp[k] <= PRESET & KEEP;
         end else if (wr_en && wr_idx == MY_IDX) begin
            for (int k = 0; k < 3; k++) cp[k] <= wr_data & KEEP;
         end
      end

      assign voted[r] = vote3(cp[0], cp[1], cp[2]);
      assign mism[r]  = |((cp[0] ^ cp[1]) | (cp[0] ^ cp[2]));
      assign cfg_flat[r*DW +: DW] = voted[r];

      p_copies_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && wr_idx == MY_IDX |=> cp[0] == cp[1] && cp[1] == cp[2]
                                       && cp[0] == $past(wr_data & KEEP))
         else $error("copies differ after write");

      if (r != PAD_IDX) begin : g_mask
         p_pad_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !voted[r][PAD_BIT])
            else $error("pad enable stored outside its register");
      end
   end

   always_comb begin
      rd_data = '0;
      for (int r = 0; r < NREG; r++)
         if (rd_idx == IW'(r)) rd_data = voted[r];
   end

   assign mismatch = |mism;

   p_vote_clean_r5: assert property (@(posedge clk) disable iff (!rst_n) !mismatch)
      else $error("copy disagreement without a fault");

endmodule

// File: rtl/dllcfg_spi_slave.sv
module dllcfg_spi_slave
   import dllcfg_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CFG_PER_CH  = 2,
   parameter int CFG_W       = 16,
   parameter int STAT_W      = 8,
   parameter int CMD_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PAD_IDX     = 2,
   parameter int PAD_BIT     = 2,
   localparam int NCFG       = NUM_CH * CFG_PER_CH,
   localparam int IDX_W      = CMD_W - 3,
   localparam int FLAG_W     = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     spi_sclk,
   input  logic                     spi_cs_n,
   input  logic                     spi_sdi,
   output logic                     spi_sdo_pull,
   input  logic [NUM_CH*FLAG_W-1:0] chan_stat,
   output logic [NCFG*CFG_W-1:0]    cfg_word,
   output logic                     pump_clr,
   output logic                     tmr_mismatch
);
   initial begin
      assert (CMD_W == 8) else $error("command must be one byte");
      assert (STAT_W > FLAG_W && STAT_W < CFG_W) else $error("bad status width");
      assert (NCFG <= (1 << IDX_W)) else $error("too many config registers");
      assert (NUM_CH <= (1 << IDX_W)) else $error("too many channels");
      assert (PAD_IDX < NCFG && PAD_BIT < CFG_W) else $error("bad pad position");
      assert (SYNC_STAGES >= 2) else $error("need two sync stages");
   end

   logic sclk_rise, sclk_fall, active, sdi_s;
   logic wr_en;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [CFG_W-1:0] wr_data, rd_cfg;
   logic [STAT_W-1:0] rd_stat;

   spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .sdi(spi_sdi),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .active(active), .sdi_s(sdi_s));

   spi_frame_ctrl #(.CW(CMD_W), .DW(CFG_W), .SW(STAT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .active(active), .sdi_s(sdi_s), .rd_idx(rd_idx), .rd_cfg(rd_cfg),
      .rd_stat(rd_stat), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .pump_clr(pump_clr), .drv_low(spi_sdo_pull));

   tmr_cfg_bank #(.NREG(NCFG), .DW(CFG_W), .IW(IDX_W), .PAD_IDX(PAD_IDX),
                  .PAD_BIT(PAD_BIT), .PRESET(CFG_PRESET)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_cfg), .cfg_flat(cfg_word), .mismatch(tmr_mismatch));

   always_comb begin
      rd_stat = '0;
      for (int ch = 0; ch < NUM_CH; ch++)
         if (rd_idx == IDX_W'(ch))
            rd_stat = {chan_stat[ch*FLAG_W +: FLAG_W], {(STAT_W-FLAG_W){1'b0}}};
   end

   p_idle_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(spi_cs_n) && spi_cs_n && !active |=> !spi_sdo_pull)
      else $error("serial output pulled while deselected");

endmodule

// File: tb/dllcfg_spi_slave_tb_top.sv
module dllcfg_spi_slave_tb_top;
   localparam int NCFG = 8;
   localparam int HALF = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, sclk, cs_n, sdi, sdo_pull, pump_clr, mism;
   logic [11:0]  chan_stat;
   logic [127:0] cfg_word;

   dllcfg_spi_slave dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
      .spi_sdo_pull(sdo_pull), .chan_stat(chan_stat), .cfg_word(cfg_word),
      .pump_clr(pump_clr), .tmr_mismatch(mism));

   wire line = ~sdo_pull;

   int n_chk = 0, n_fail = 0, pumps = 0;
   logic [15:0] model [NCFG];

   always @(posedge clk) if (rst_n && pump_clr) pumps++;

   function automatic logic [15:0] fold(input int idx, input logic [15:0] v);
      return (idx == 2) ? v : (v & 16'hFFFB);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] cmd, input logic [15:0] wd, input int nd,
                       output logic [15:0] rd);
      logic quiet;
      quiet = 1'b1;
      rd = 16'hFFFF;
      cs_n = 1'b0;
      ticks(HALF);
      for (int i = 0; i < 8; i++) begin
         sclk = 1'b1; sdi = cmd[7-i];
         ticks(HALF);
         quiet &= line;
         sclk = 1'b0;
         ticks(HALF);
      end
      for (int i = 0; i < nd; i++) begin
         sclk = 1'b1; sdi = wd[15-i];
         ticks(HALF);
         rd[15-i] = line;
         sclk = 1'b0;
         ticks(HALF);
      end
      ticks(HALF);
      cs_n = 1'b1; sdi = 1'b1;
      ticks(4*HALF);
      check("R12 command phase released", {31'd0, quiet}, 32'd1);
      check("R12 idle released", {31'd0, sdo_pull}, 32'd0);
   endtask

   task automatic check_cfg(input string tag);
      for (int r = 0; r < NCFG; r++) check(tag, {16'd0, cfg_word[r*16 +: 16]}, {16'd0, model[r]});
      check("R5 vote clean", {31'd0, mism}, 32'd0);
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] rd;
      logic [15:0] wd;
      int pump0, idx, op, nd;
      void'($urandom(32'd20130412));
      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b1; chan_stat = '0;
      for (int r = 0; r < NCFG; r++) model[r] = 16'h9E00;
      ticks(10);
      check_cfg("R1 preset in reset");
      check("R1 sdo released", {31'd0, sdo_pull}, 32'd0);
      check("R1 no pump", {31'd0, pump_clr}, 32'd0);
      rst_n = 1'b1;
      ticks(5);
      check_cfg("R1 preset after reset");

      // R3 R10: pad bit kept only at index 2
      xfer(8'h02, 16'hFFFF, 16, rd); model[2] = 16'hFFFF;
      xfer(8'h00, 16'hFFFF, 16, rd); model[0] = 16'hFFFB;
      check_cfg("R10 pad bit mask");
      xfer(8'h80, 16'h0000, 16, rd);
      check("R10 R4 read idx0", {16'd0, rd}, {16'd0, 16'hFFFB});
      xfer(8'h82, 16'h0000, 16, rd);
      check("R4 read idx2", {16'd0, rd}, {16'd0, 16'hFFFF});

      // R2 R3 R4: distinct pattern
      xfer(8'h05, 16'h1234, 16, rd); model[5] = 16'h1230;
      check_cfg("R3 write idx5");
      xfer(8'h85, 16'h0000, 16, rd);
      check("R2 R4 read idx5", {16'd0, rd}, {16'd0, 16'h1230});

      // R7: abort after 15 data bits
      xfer(8'h05, 16'hABCD, 15, rd);
      check_cfg("R7 aborted write");

      // R11: status-bank write, out-of-range write and read
      xfer(8'h25, 16'h5555, 16, rd);
      xfer(8'h14, 16'h5555, 16, rd);
      check_cfg("R11 ignored writes");
      xfer(8'h94, 16'h0000, 16, rd);
      check("R11 unimplemented read", {16'd0, rd}, 32'd0);

      // R6: pump clear, no register write
      pump0 = pumps;
      xfer(8'h45, 16'h1111, 16, rd);
      check("R6 one pump pulse", pumps - pump0, 1);
      check_cfg("R6 no register change");
      xfer(8'h40, 16'h0000, 0, rd);
      check("R6 plain pump cmd", pumps - pump0, 2);

      // R9: loop-through
      pump0 = pumps;
      xfer(8'hFF, 16'hA5C3, 16, rd);
      check("R9 loop data", {16'd0, rd}, {16'd0, 16'hA5C3});
      check("R9 no pump", pumps - pump0, 0);
      check_cfg("R9 no register change");

      // R8: status directed
      chan_stat = 12'b101_010_110_001;
      xfer(8'hA0, 16'h0000, 8, rd);
      check("R8 status ch0", {24'd0, rd[15:8]}, {24'd0, 8'b001_00000});
      xfer(8'hA3, 16'h0000, 8, rd);
      check("R8 status ch3", {24'd0, rd[15:8]}, {24'd0, 8'b101_00000});
      xfer(8'hA7, 16'h0000, 8, rd);
      check("R8 status out of range", {24'd0, rd[15:8]}, 32'd0);

      // random mix
      for (int it = 0; it < 60; it++) begin
         op = int'($urandom % 4);
         idx = int'($urandom % 10);
         wd = 16'($urandom);
         case (op)
            0: begin
               xfer({3'b000, 5'(idx)}, wd, 16, rd);
               if (idx < NCFG) model[idx] = fold(idx, wd);
               check_cfg("R3 random write");
            end
            1: begin
               xfer({3'b100, 5'(idx)}, 16'h0000, 16, rd);
               check("R4 random read", {16'd0, rd}, {16'd0, (idx < NCFG) ? model[idx] : 16'h0000});
            end
            2: begin
               nd = int'($urandom % 16);
               xfer({3'b000, 5'(idx)}, wd, nd, rd);
               check_cfg("R7 random abort");
            end
            default: begin
               chan_stat = 12'($urandom);
               idx = idx % 6;
               xfer({3'b101, 5'(idx)}, 16'h0000, 8, rd);
               check("R8 random status", {24'd0, rd[15:8]},
                     {24'd0, (idx < 4) ? {chan_stat[idx*3 +: 3], 5'b00000} : 8'h00});
            end
         endcase
      end

      summary();
      $finish;
   end
endmodule